// File: doc/BRIEF.md
# Split-Priority Read Return Buffer

This block buffers returning read data for four requesters in one fixed pool of 32 storage words. When splitting is switched on, the pool is cut at a programmable boundary into an urgent region and a bulk region. The two regions need not be equal; a few urgent words beside a large bulk region is a normal setting. A static map assigns each requester to one of the two regions. Every incoming word carries its requester number and is stored in the region of that requester.

Each region is a ring buffer with its own output handshake. A slow bulk consumer that stalls its output therefore never delays urgent traffic. When splitting is off, which is the reset setting, the whole pool forms a single bulk queue and the urgent output stays idle. Acceptance is signalled per requester: a requester whose region is full sees its ready bit low, while requesters of the other region continue to be accepted.

The boundary, the enable and the map are quasi-static. They may be changed only while both regions are empty.

Top module: `prio_split_rdq`

## Requirements
- R1: After reset both outputs are not valid, `lo_full` is 0, `hi_full` is 1 (splitting off, so the urgent region has no capacity) and every bit of `in_ready` is 1.
- R2: With `cfg_split_en` = 0, every requester is steered to the bulk region whatever `cfg_port_hi` holds. The bulk region then holds all DEPTH words, `hi_valid` never rises and `hi_full` stays 1.
- R3: With `cfg_split_en` = 1, a word from requester p goes to the urgent region when bit p of `cfg_port_hi` is 1, and to the bulk region when that bit is 0.
- R4: With splitting on, the urgent region holds exactly `cfg_hi_entries` words (legal range 1 to DEPTH-1) and the bulk region holds DEPTH minus that. Each full flag is 1 exactly when its region holds its capacity.
- R5: `in_ready[p]` is 0 exactly when the region of requester p is full. A word offered while that bit is 0 is dropped, and this leaves the other region's readiness and contents unaffected. A word is taken when `in_valid` and `in_ready[in_port]` are both 1 at a rising edge.
- R6: Each region returns its words in arrival order, including across wrap-around of its address range. A word is removed when its output valid and ready are both 1 at a rising edge.
- R7: The urgent output keeps draining while the bulk output is stalled with a full bulk region, and the reverse also holds.
- R8: Readiness of a full region stays 0 in a cycle where that region is also being drained. Room freed by a drain becomes usable from the following cycle.
- R9: After both regions are empty, a new boundary, enable or map takes effect for the next words, and the capacities follow the new boundary. Configuration must not change while any word is stored.
- R10: While an output is valid and not ready, it stays valid and its data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split_en | input | 1 | 1 splits the pool into urgent and bulk regions |
| cfg_hi_entries | input | AW (5) | Urgent region size in words, 1 to DEPTH-1 |
| cfg_port_hi | input | NPORTS (4) | Bit p set assigns requester p to the urgent region |
| in_valid | input | 1 | Incoming word present |
| in_port | input | PID_W (2) | Requester number of the incoming word |
| in_data | input | DATA_W (32) | Incoming word |
| in_ready | output | NPORTS (4) | Bit p: the region of requester p has room |
| hi_valid | output | 1 | Urgent region has a word at its head |
| hi_data | output | DATA_W (32) | Urgent head word |
| hi_ready | input | 1 | Urgent consumer takes the head word |
| hi_full | output | 1 | Urgent region at capacity |
| lo_valid | output | 1 | Bulk region has a word at its head |
| lo_data | output | DATA_W (32) | Bulk head word |
| lo_ready | input | 1 | Bulk consumer takes the head word |
| lo_full | output | 1 | Bulk region at capacity |

## Verification
The bench fills each region to its exact boundary and offers one more word. A design that computed capacity off by one would either refuse the last legal word or overwrite the oldest. It stalls the bulk output with a full bulk region while draining the urgent one; a design that shares a head pointer or a full flag between regions would hold the urgent words back. It runs long random traffic with the boundary at 1 and at 31 so that both rings wrap many times, where a wrong modulo would corrupt the order the scoreboard expects. It also offers words with splitting off but a non-zero map, which catches a design that leaks words into the disabled urgent region.

// File: rtl/psq_pkg.sv
package psq_pkg;

   // Destination region of a stored word.
   typedef enum logic {
      SIDE_LO = 1'b0,
      SIDE_HI = 1'b1
   } side_e;

endpackage

// File: rtl/psq_pool.sv
// Shared word storage: one write port, two asynchronous read ports.
module psq_pool #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 32,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);

   generate
      if (DEPTH < 2) begin : g_chk_depth
         $error("psq_pool: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_chk_width
         $error("psq_pool: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         words[waddr] <= wdata;
      end
   end

   assign rdata_a = words[raddr_a];
   assign rdata_b = words[raddr_b];

endmodule

// File: rtl/psq_ring.sv
// One region of the pool: a ring confined to [base, base+size).
// Offsets are kept relative to base, so base may move while empty.
module psq_ring #(
   parameter int DEPTH = 32,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] size,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          full,
   output logic          empty
);

   localparam int SW = CW + 1;

   logic [AW-1:0] rd_off_q, rd_off_d, rd_inc;
   logic [CW-1:0] count_q, count_d;
   logic [SW-1:0] wsum, wr_off;

   assign full  = (count_q == size);
   assign empty = (count_q == '0);

   // Write offset = (read offset + occupancy) modulo size.
   always_comb begin
      wsum = SW'(rd_off_q) + SW'(count_q);
      if (wsum >= SW'(size)) begin
         wr_off = wsum - SW'(size);
      end else begin
         wr_off = wsum;
      end
   end

   assign wr_addr = base + AW'(wr_off);
   assign rd_addr = base + rd_off_q;

   always_comb begin
      rd_inc = rd_off_q + AW'(1);
      if (CW'(rd_inc) == size) begin
         rd_inc = '0;
      end
   end

   always_comb begin
      count_d = count_q;
      unique case ({push, pop})
         2'b10:   count_d = count_q + CW'(1);
         2'b01:   count_d = count_q - CW'(1);
         default: count_d = count_q;
      endcase
      rd_off_d = pop ? rd_inc : rd_off_q;
      if (count_d == '0) begin
         rd_off_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         rd_off_q <= '0;
      end else begin
         count_q  <= count_d;
         rd_off_q <= rd_off_d;
      end
   end

   // R4: occupancy never exceeds the region capacity.
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= size)
      else $error("ring occupancy above capacity");

   // R5: the steering logic only writes into a region with room.
   p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full)
      else $error("write into a full region");

   // R6: a removal only happens with a stored word.
   p_pop_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty)
      else $error("removal from an empty region");

   // R6: occupancy moves by at most one word per cycle.
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push != pop) |=> (count_q != $past(count_q)))
      else $error("occupancy did not follow a single push or pop");

endmodule

// File: rtl/psq_steer.sv
// Per-requester region choice and acceptance.
module psq_steer
   import psq_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int PID_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              split_en,
   input  logic [NPORTS-1:0] port_hi,
   input  logic              in_valid,
   input  logic [PID_W-1:0]  in_port,
   input  logic              hi_full,
   input  logic              lo_full,
   output logic [NPORTS-1:0] in_ready,
   output logic              push_hi,
   output logic              push_lo
);

   side_e       route [NPORTS];
   side_e       sel_side;
   logic        sel_ready;

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_port
         assign route[p]    = (split_en && port_hi[p]) ? SIDE_HI : SIDE_LO;
         assign in_ready[p] = (route[p] == SIDE_HI) ? !hi_full : !lo_full;
      end
      if ((1 << PID_W) > NPORTS) begin : g_sparse_id
         // Requester numbers beyond NPORTS are never accepted.
         always_comb begin
            if (int'(in_port) < NPORTS) begin
               sel_side  = route[in_port];
               sel_ready = in_ready[in_port];
            end else begin
               sel_side  = SIDE_LO;
               sel_ready = 1'b0;
            end
         end
      end else begin : g_dense_id
         assign sel_side  = route[in_port];
         assign sel_ready = in_ready[in_port];
      end
   endgenerate

   assign push_hi = in_valid && sel_ready && (sel_side == SIDE_HI);
   assign push_lo = in_valid && sel_ready && (sel_side == SIDE_LO);

endmodule

// File: rtl/prio_split_rdq.sv
module prio_split_rdq #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int NPORTS = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int PID_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_split_en,
   input  logic [AW-1:0]     cfg_hi_entries,
   input  logic [NPORTS-1:0] cfg_port_hi,
   input  logic              in_valid,
   input  logic [PID_W-1:0]  in_port,
   input  logic [DATA_W-1:0] in_data,
   output logic [NPORTS-1:0] in_ready,
   output logic              hi_valid,
   output logic [DATA_W-1:0] hi_data,
   input  logic              hi_ready,
   output logic              hi_full,
   output logic              lo_valid,
   output logic [DATA_W-1:0] lo_data,
   input  logic              lo_ready,
   output logic              lo_full
);

   generate
      if (DEPTH < 4) begin : g_chk_depth
         $error("prio_split_rdq: DEPTH must be at least 4");
      end
      if (NPORTS < 1) begin : g_chk_ports
         $error("prio_split_rdq: NPORTS must be positive");
      end
   endgenerate

   logic [CW-1:0] hi_size, lo_size;
   logic [AW-1:0] lo_base;
   logic          push_hi, push_lo, pop_hi, pop_lo;
   logic          hi_empty, lo_empty;
   logic [AW-1:0] hi_wr, hi_rd, lo_wr, lo_rd;

   // Urgent region occupies the low addresses, bulk region the rest.
   assign hi_size = cfg_split_en ? CW'(cfg_hi_entries) : '0;
   assign lo_size = CW'(DEPTH) - hi_size;
   assign lo_base = AW'(hi_size);

   psq_steer #(
      .NPORTS (NPORTS),
      .PID_W  (PID_W)
   ) u_steer (
      .split_en (cfg_split_en),
      .port_hi  (cfg_port_hi),
      .in_valid (in_valid),
      .in_port  (in_port),
      .hi_full  (hi_full),
      .lo_full  (lo_full),
      .in_ready (in_ready),
      .push_hi  (push_hi),
      .push_lo  (push_lo)
   );

   psq_ring #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ring_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .base    ('0),
      .size    (hi_size),
      .push    (push_hi),
      .pop     (pop_hi),
      .wr_addr (hi_wr),
      .rd_addr (hi_rd),
      .full    (hi_full),
      .empty   (hi_empty)
   );

   psq_ring #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ring_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .base    (lo_base),
      .size    (lo_size),
      .push    (push_lo),
      .pop     (pop_lo),
      .wr_addr (lo_wr),
      .rd_addr (lo_rd),
      .full    (lo_full),
      .empty   (lo_empty)
   );

   psq_pool #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_pool (
      .clk     (clk),
      .we      (push_hi || push_lo),
      .waddr   (push_hi ? hi_wr : lo_wr),
      .wdata   (in_data),
      .raddr_a (hi_rd),
      .raddr_b (lo_rd),
      .rdata_a (hi_data),
      .rdata_b (lo_data)
   );

   assign hi_valid = !hi_empty;
   assign lo_valid = !lo_empty;
   assign pop_hi   = hi_valid && hi_ready;
   assign pop_lo   = lo_valid && lo_ready;

   // R10: a stalled urgent head is held.
   p_hold_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_valid && !hi_ready) |=> (hi_valid && $stable(hi_data)))
      else $error("urgent head changed while stalled");

   // R10: a stalled bulk head is held.
   p_hold_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_valid && !lo_ready) |=> (lo_valid && $stable(lo_data)))
      else $error("bulk head changed while stalled");

   // R2: with splitting off nothing appears on the urgent output.
   p_off_no_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_split_en |-> (!hi_valid && hi_full))
      else $error("urgent output active with splitting off");

   // R9: configuration moves only while both regions are empty.
   p_cfg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cfg_split_en) || !$stable(cfg_hi_entries) || !$stable(cfg_port_hi))
         |-> (hi_empty && lo_empty))
      else $error("configuration changed with stored words");

   // R4: legal boundary while split.
   p_split_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_split_en |-> (cfg_hi_entries != '0))
      else $error("urgent region size of zero");

endmodule

// File: tb/prio_split_rdq_bench.sv
module prio_split_rdq_bench;

   localparam int DW    = 32;
   localparam int DEPTH = 32;
   localparam int NP    = 4;
   localparam int AW    = 5;
   localparam int PW    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_split_en = 1'b0;
   logic [AW-1:0] cfg_hi_entries = AW'(4);
   logic [NP-1:0] cfg_port_hi = '0;
   logic          in_valid = 1'b0;
   logic [PW-1:0] in_port = '0;
   logic [DW-1:0] in_data = '0;
   logic [NP-1:0] in_ready;
   logic          hi_valid, lo_valid, hi_full, lo_full;
   logic [DW-1:0] hi_data, lo_data;
   logic          hi_ready = 1'b0;
   logic          lo_ready = 1'b0;

   always #2 clk = ~clk;

   prio_split_rdq #(.DATA_W(DW), .DEPTH(DEPTH), .NPORTS(NP)) u_prio_split_rdq (
      .clk, .rst_n, .cfg_split_en, .cfg_hi_entries, .cfg_port_hi,
      .in_valid, .in_port, .in_data, .in_ready,
      .hi_valid, .hi_data, .hi_ready, .hi_full,
      .lo_valid, .lo_data, .lo_ready, .lo_full
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [DW-1:0] q_hi[$];
   logic [DW-1:0] q_lo[$];
   int acc_hi = 0, acc_lo = 0, pop_hi_n = 0, pop_lo_n = 0;
   bit hi_rdy_en = 0, lo_rdy_en = 0, rnd_rdy = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit goes_hi(input int p);
      return cfg_split_en && cfg_port_hi[p];
   endfunction

   function automatic int cap_of(input bit hi);
      if (!cfg_split_en) return hi ? 0 : DEPTH;
      return hi ? int'(cfg_hi_entries) : DEPTH - int'(cfg_hi_entries);
   endfunction

   // Port-level occupancy counters, updated at the edge.
   always @(posedge clk) begin
      if (rst_n) begin
         if (in_valid && in_ready[in_port]) begin
            if (goes_hi(int'(in_port))) acc_hi++;
            else acc_lo++;
         end
         if (hi_valid && hi_ready) pop_hi_n++;
         if (lo_valid && lo_ready) pop_lo_n++;
      end
   end

   // Monitor: drives consumer readiness and pops the scoreboard.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         hi_ready = rnd_rdy ? 1'($urandom % 2) : hi_rdy_en;
         lo_ready = rnd_rdy ? 1'($urandom % 2) : lo_rdy_en;
         if (hi_valid && hi_ready) begin
            if (q_hi.size() == 0) chk(0, "R6 urgent word not expected", hi_data, 0);
            else begin
               logic [DW-1:0] e;
               e = q_hi.pop_front();
               chk(hi_data == e, "R6 urgent order", hi_data, e);
            end
         end
         if (lo_valid && lo_ready) begin
            if (q_lo.size() == 0) chk(0, "R6 bulk word not expected", lo_data, 0);
            else begin
               logic [DW-1:0] e;
               e = q_lo.pop_front();
               chk(lo_data == e, "R6 bulk order", lo_data, e);
            end
         end
      end
   end

   // Driver: offers one word; checks readiness against the model.
   task automatic offer(input int p, input logic [DW-1:0] d, output bit acc);
      bit hi;
      int occ;
      bit exp_rdy;
      @(negedge clk);
      in_valid = 1'b1;
      in_port  = PW'(p);
      in_data  = d;
      hi       = goes_hi(p);
      occ      = hi ? (acc_hi - pop_hi_n) : (acc_lo - pop_lo_n);
      exp_rdy  = (occ < cap_of(hi));
      chk(in_ready[p] == exp_rdy, "R4/R5 ready vs capacity", in_ready[p], exp_rdy);
      acc = in_ready[p];
      if (acc) begin
         if (hi) q_hi.push_back(d);
         else q_lo.push_back(d);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic fill(input int p, input int max, input logic [DW-1:0] tagv, output int n);
      bit a;
      n = 0;
      for (int i = 0; i < max; i++) begin
         offer(p, tagv + DW'(i), a);
         if (!a) break;
         n++;
      end
      idle();
   endtask

   task automatic drain_all(input string tag);
      @(posedge clk);
      rnd_rdy = 0;
      hi_rdy_en = 1;
      lo_rdy_en = 1;
      for (int i = 0; i < 500; i++) begin
         @(posedge clk);
         if (q_hi.size() == 0 && q_lo.size() == 0 &&
             acc_hi == pop_hi_n && acc_lo == pop_lo_n) break;
      end
      @(negedge clk);
      chk(!hi_valid && !lo_valid, tag, {hi_valid, lo_valid}, 0);
      chk(q_hi.size() == 0 && q_lo.size() == 0, tag, q_hi.size() + q_lo.size(), 0);
   endtask

   task automatic random_run(input int n, input logic [DW-1:0] seedv);
      bit a;
      @(posedge clk);
      rnd_rdy = 1;
      for (int i = 0; i < n; i++) begin
         offer(int'($urandom % NP), seedv ^ DW'($urandom), a);
         if ((i % 7) == 3) idle();
      end
      idle();
      drain_all("R6 random traffic drained");
   endtask

   initial begin
      bit a;
      int n;
      int base_pop;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!hi_valid && !lo_valid, "R1 outputs idle", {hi_valid, lo_valid}, 0);
      chk(hi_full == 1'b1 && lo_full == 1'b0, "R1 full flags", {hi_full, lo_full}, 2);
      chk(in_ready == 4'hF, "R1 all requesters ready", in_ready, 4'hF);

      // R2: splitting off, map ignored, whole pool is bulk
      cfg_port_hi = 4'b0101;
      fill(0, 40, 32'hA000_0000, n);
      chk(n == DEPTH, "R2 bulk capacity with split off", n, DEPTH);
      chk(lo_full && !hi_valid && hi_full, "R2 state after fill", {lo_full, hi_valid, hi_full}, 5);
      offer(2, 32'hDEAD_0001, a);
      idle();
      chk(!a, "R5 word refused when bulk full", a, 0);
      base_pop = pop_lo_n;
      drain_all("R2 drained after split-off fill");
      chk(pop_lo_n - base_pop == DEPTH, "R5 refused word not stored", pop_lo_n - base_pop, DEPTH);

      // R9/R3/R4: split 4/28, requesters 0 and 2 urgent
      @(negedge clk);
      cfg_split_en   = 1'b1;
      cfg_hi_entries = AW'(4);
      @(posedge clk);
      hi_rdy_en = 0;
      lo_rdy_en = 0;
      fill(0, 10, 32'hB000_0000, n);
      chk(n == 4, "R4 urgent capacity 4", n, 4);
      chk(hi_full && !lo_full, "R5 only urgent full", {hi_full, lo_full}, 2);
      chk(in_ready == 4'b1010, "R5 per-requester readiness", in_ready, 4'b1010);
      offer(1, 32'hC000_0000, a);
      idle();
      chk(a, "R3 bulk requester accepted while urgent full", a, 1);
      chk(lo_valid && hi_valid, "R3 both regions hold words", {hi_valid, lo_valid}, 3);
      fill(3, 40, 32'hC100_0000, n);
      chk(n == 27, "R4 bulk capacity 28", n + 1, 28);
      chk(lo_full, "R4 bulk full flag", lo_full, 1);

      // R7: urgent drains while bulk stalled
      @(posedge clk);
      hi_rdy_en = 1;
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(q_hi.size() == 0 && !hi_valid, "R7 urgent drained past stalled bulk", q_hi.size(), 0);
      chk(lo_valid && q_lo.size() == 28, "R7 bulk untouched", q_lo.size(), 28);

      // R8: full bulk being drained still refuses in that cycle
      @(posedge clk);
      lo_rdy_en = 1;
      offer(3, 32'hEEEE_0000, a);
      chk(!a, "R8 no acceptance while full and draining", a, 1'b0);
      offer(3, 32'hEEEE_0001, a);
      chk(a, "R8 freed room usable next cycle", a, 1);
      idle();
      drain_all("R6 split 4/28 drained");

      // R7 reverse: bulk drains while urgent stalled
      @(posedge clk);
      hi_rdy_en = 0;
      lo_rdy_en = 0;
      fill(2, 4, 32'hF000_0000, n);
      fill(1, 5, 32'hF100_0000, n);
      @(posedge clk);
      lo_rdy_en = 1;
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(q_lo.size() == 0 && hi_valid && q_hi.size() == 4, "R7 bulk drained past stalled urgent",
          q_hi.size(), 4);
      drain_all("R7 reverse drained");

      // R9: new boundary 31, only requester 3 urgent
      @(negedge clk);
      cfg_hi_entries = AW'(31);
      cfg_port_hi    = 4'b1000;
      @(posedge clk);
      hi_rdy_en = 0;
      lo_rdy_en = 0;
      fill(3, 40, 32'h1100_0000, n);
      chk(n == 31, "R9 urgent capacity follows new boundary", n, 31);
      fill(0, 40, 32'h1200_0000, n);
      chk(n == 1, "R9 bulk capacity 1", n, 1);
      drain_all("R9 drained");
      random_run(400, 32'h3100_0000);

      // R6: boundary 1, wrap-around stress
      @(negedge clk);
      cfg_hi_entries = AW'(1);
      cfg_port_hi    = 4'b0011;
      random_run(400, 32'h0100_0000);

      // R2: random traffic with split off and a full map
      @(negedge clk);
      cfg_split_en = 1'b0;
      cfg_port_hi  = 4'b1111;
      random_run(300, 32'h0000_0000);
      chk(acc_hi == 0 || pop_hi_n == acc_hi, "R2 urgent count consistent", acc_hi, pop_hi_n);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL R6 watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule